// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block is the host-facing register unit of a single-master I2C controller. A simple 32-bit register bus (byte address, write strobe, read strobe, write data, registered read data) reaches a small register file. The data offset is shared: a write queues a command word for the serial engine, and a read takes one received byte. Status, control, two SCL phase dividers, an own-address register, FIFO fill levels and per-direction byte counters make up the rest.

On the engine side the block presents the head of the command queue, accepts received bytes, and takes event pulses and bus levels that feed the status word. The sticky event flags are cleared by writing one. Enabled flags are merged into one registered, level-sensitive interrupt. A control bit starts a timed soft reset. While it runs, both queues, the byte counters and the sticky flags are held clear and the engine is held in reset. The bit then clears itself.

Top module: `i2c_regfront`

## Requirements
- R1: After the synchronous reset, status reads 0x00000A00 (bit 9 RX empty, bit 11 TX empty) with all engine inputs low. Control reads 0, both dividers read 0x3FF, and irq and bus_rdata are 0.
- R2: A write to offset 0x00 queues wdata[9:0] in the TX FIFO. eng_tx_valid is high while the FIFO holds an entry and no soft reset is running. eng_tx_data shows the oldest entry, and eng_tx_pop with eng_tx_valid removes it, in first-in first-out order.
- R3: A write to 0x00 while the TX FIFO holds DEPTH entries is dropped. Offset 0x1C reads the TX fill level, status bit 10 reports full and bit 11 reports empty.
- R4: A read of 0x00 returns the oldest received byte in bits [7:0] and removes it. With the RX FIFO empty it returns 0. Offset 0x18 reads the RX fill level, status bit 8 reports full and bit 9 reports empty.
- R5: A byte pushed by the engine while the RX FIFO holds DEPTH entries is dropped.
- R6: Status bit 0 (transfer done) and bit 1 (arbitration lost) are set by eng_done_set and eng_arb_set and stay set. Writing 1 to a bit at offset 0x04 clears it, and writing 0 leaves it. A set in the same cycle as a clear wins.
- R7: Status bits 2 (no-ack), 3 (needs data), 5 (bus active), 6 (SCL) and 7 (SDA) follow the engine inputs.
- R8: irq rises one cycle after any enabled pair is true. The pairs are done/ctrl bit 0, arbitration/bit 1, no-ack/bit 2, needs-data/bit 3, RX full/bit 5 and RX not empty/bit 6.
- R9: Writing 1 to control bit 8 holds eng_reset and control bit 8 high for RST_LEN cycles. During that time both FIFOs are emptied, TX writes and engine pushes are dropped, and the byte counters and status bits 0 and 1 are cleared. The other control bits keep their written value. Control bit 10 drives eng_combined, and bit 9 reads 0.
- R10: Offset 0x20 counts engine receive pushes and offset 0x24 counts accepted engine pops.
- R11: Offsets 0x0C and 0x10 hold the 10-bit SCL low and high dividers from wdata[9:0]. They drive scl_lo_div and scl_hi_div.
- R12: Offset 0x14 holds a 7-bit own address on own_addr. Offsets 0x28, 0x2C and unmapped offsets read 0.
- R13: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_tx_valid | output | 1 | Command queue has an entry for the engine |
| eng_tx_data | output | 10 | Oldest command word |
| eng_tx_pop | input | 1 | Engine takes the oldest command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done_set | input | 1 | Transfer-done event pulse |
| eng_arb_set | input | 1 | Arbitration-lost event pulse |
| eng_nak | input | 1 | No-acknowledge level |
| eng_need_data | input | 1 | Engine needs transmit data |
| eng_busy | input | 1 | Bus active level |
| eng_scl | input | 1 | SCL line level |
| eng_sda | input | 1 | SDA line level |
| eng_reset | output | 1 | Engine held in reset during soft reset |
| eng_combined | output | 1 | Combined-data mode select |
| scl_lo_div | output | 10 | SCL low phase divider |
| scl_hi_div | output | 10 | SCL high phase divider |
| own_addr | output | 7 | Own bus address |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the overlap of a soft reset with traffic. A TX write issued in the first reset cycle must be lost, and the FIFOs must come out empty while the other control bits survive. The stimulus writes the control register and the data offset on consecutive cycles, then reads control while the reset runs and reads status and levels afterwards. The same-cycle set and write-one-clear of the done flag is driven deliberately. A randomised phase mixes bus accesses, engine pushes and pops, and event pulses, and a queue-based model is compared on every clock.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_DLO   = 8'h0C;
  localparam logic [7:0] OFS_DHI   = 8'h10;
  localparam logic [7:0] OFS_OWN   = 8'h14;
  localparam logic [7:0] OFS_RXLVL = 8'h18;
  localparam logic [7:0] OFS_TXLVL = 8'h1C;
  localparam logic [7:0] OFS_RXCNT = 8'h20;
  localparam logic [7:0] OFS_TXCNT = 8'h24;

  localparam int CB_RESET    = 8;
  localparam int CB_COMBINED = 10;
  localparam logic [10:0] CTRL_KEEP = 11'h4FF;

  localparam int TX_W = 10;
  localparam int RX_W = 8;
  localparam int IRQ_N = 6;
endpackage

// File: rtl/i2c_rf_fifo.sv
module i2c_rf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/i2c_rf_rstseq.sv
module i2c_rf_rstseq #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_LEN+1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CW'(RST_LEN);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/i2c_rf_irq.sv
module i2c_rf_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_pair
    assign hit[i] = flags[i] & enables[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DEPTH   = 4,
  parameter int RST_LEN = 4,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 10,
  parameter int ADR_W   = 7,
  parameter logic [DIV_W-1:0] DIV_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_tx_valid,
  output logic [9:0]        eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  input  logic              eng_done_set,
  input  logic              eng_arb_set,
  input  logic              eng_nak,
  input  logic              eng_need_data,
  input  logic              eng_busy,
  input  logic              eng_scl,
  input  logic              eng_sda,
  output logic              eng_reset,
  output logic              eng_combined,
  output logic [DIV_W-1:0]  scl_lo_div,
  output logic [DIV_W-1:0]  scl_hi_div,
  output logic [ADR_W-1:0]  own_addr,
  output logic              irq
);
  localparam int LVL_W = $clog2(DEPTH+1);

  function automatic logic hit(input logic [7:0] ofs);
    return bus_addr == ADDR_W'(ofs);
  endfunction

  logic wr_data, rd_data, wr_stat, wr_ctrl;
  assign wr_data = bus_wr && hit(OFS_DATA);
  assign rd_data = bus_rd && hit(OFS_DATA);
  assign wr_stat = bus_wr && hit(OFS_STAT);
  assign wr_ctrl = bus_wr && hit(OFS_CTRL);

  logic busy;
  i2c_rf_rstseq #(.RST_LEN(RST_LEN)) u_rstseq (
    .clk(clk), .rst(rst),
    .start(wr_ctrl && bus_wdata[CB_RESET]),
    .busy(busy)
  );
  assign eng_reset = busy;

  logic [TX_W-1:0]  tx_head;
  logic             tx_full, tx_empty;
  logic [LVL_W-1:0] tx_level;
  i2c_rf_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(busy),
    .push(wr_data), .din(bus_wdata[TX_W-1:0]),
    .pop(eng_tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_level)
  );
  assign eng_tx_valid = !tx_empty && !busy;
  assign eng_tx_data  = tx_head;

  logic [RX_W-1:0]  rx_head;
  logic             rx_full, rx_empty;
  logic [LVL_W-1:0] rx_level;
  i2c_rf_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(busy),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_data), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  logic done_q, arb_q;
  always_ff @(posedge clk) begin
    if (rst || busy) begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (eng_done_set)                done_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) done_q <= 1'b0;
      if (eng_arb_set)                 arb_q <= 1'b1;
      else if (wr_stat && bus_wdata[1]) arb_q <= 1'b0;
    end
  end

  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  always_ff @(posedge clk) begin
    if (rst || busy) begin
      rx_cnt <= '0;
      tx_cnt <= '0;
    end else begin
      if (eng_rx_push)                rx_cnt <= rx_cnt + 1'b1;
      if (eng_tx_pop && eng_tx_valid) tx_cnt <= tx_cnt + 1'b1;
    end
  end

  logic [10:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      scl_lo_div <= DIV_RST;
      scl_hi_div <= DIV_RST;
      own_addr   <= '0;
    end else if (bus_wr) begin
      if (hit(OFS_CTRL)) ctrl_q     <= bus_wdata[10:0] & CTRL_KEEP;
      if (hit(OFS_DLO))  scl_lo_div <= bus_wdata[DIV_W-1:0];
      if (hit(OFS_DHI))  scl_hi_div <= bus_wdata[DIV_W-1:0];
      if (hit(OFS_OWN))  own_addr   <= bus_wdata[ADR_W-1:0];
    end
  end
  assign eng_combined = ctrl_q[CB_COMBINED];

  logic [31:0] stat_w;
  always_comb begin
    stat_w     = '0;
    stat_w[0]  = done_q;
    stat_w[1]  = arb_q;
    stat_w[2]  = eng_nak;
    stat_w[3]  = eng_need_data;
    stat_w[5]  = eng_busy;
    stat_w[6]  = eng_scl;
    stat_w[7]  = eng_sda;
    stat_w[8]  = rx_full;
    stat_w[9]  = rx_empty;
    stat_w[10] = tx_full;
    stat_w[11] = tx_empty;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if      (hit(OFS_DATA))  rd_mux = rx_empty ? '0 : 32'(rx_head);
    else if (hit(OFS_STAT))  rd_mux = stat_w;
    else if (hit(OFS_CTRL))  rd_mux = 32'(ctrl_q) | (32'(busy) << CB_RESET);
    else if (hit(OFS_DLO))   rd_mux = 32'(scl_lo_div);
    else if (hit(OFS_DHI))   rd_mux = 32'(scl_hi_div);
    else if (hit(OFS_OWN))   rd_mux = 32'(own_addr);
    else if (hit(OFS_RXLVL)) rd_mux = 32'(rx_level);
    else if (hit(OFS_TXLVL)) rd_mux = 32'(tx_level);
    else if (hit(OFS_RXCNT)) rd_mux = 32'(rx_cnt);
    else if (hit(OFS_TXCNT)) rd_mux = 32'(tx_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  i2c_rf_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst),
    .flags({!rx_empty, rx_full, eng_need_data, eng_nak, arb_q, done_q}),
    .enables({ctrl_q[6], ctrl_q[5], ctrl_q[3], ctrl_q[2], ctrl_q[1], ctrl_q[0]}),
    .irq(irq)
  );
endmodule

// File: rtl/i2c_regfront_chk.sv
module i2c_regfront_chk
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              eng_done_set,
  input logic              eng_reset,
  input logic              eng_tx_valid,
  input logic              irq,
  input logic [10:0]       ctrl_q,
  input logic              done_q,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LVL_W'(DEPTH));

  p_rx_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(DEPTH));

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    eng_reset |=> !eng_tx_valid);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[6:5] == 2'b00 && ctrl_q[3:0] == 4'h0) |=> !irq);

  p_w1c_done_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[0] && !eng_done_set) |=> !done_q);

  p_set_done_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_done_set && !eng_reset) |=> done_q);

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind i2c_regfront i2c_regfront_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done_set(eng_done_set),
  .eng_reset(eng_reset), .eng_tx_valid(eng_tx_valid), .irq(irq), .ctrl_q(ctrl_q),
  .done_q(done_q), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/i2c_regfront_tb.sv
module i2c_regfront_tb;
  localparam int DEPTH = 4;
  localparam int RST_LEN = 4;

  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst = 1;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        eng_tx_valid;
  logic [9:0]  eng_tx_data;
  logic        eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  eng_rx_data = 0;
  logic        eng_done_set = 0, eng_arb_set = 0, eng_nak = 0, eng_need_data = 0;
  logic        eng_busy = 0, eng_scl = 0, eng_sda = 0;
  logic        eng_reset, eng_combined, irq;
  logic [9:0]  scl_lo_div, scl_hi_div;
  logic [6:0]  own_addr;

  i2c_regfront #(.DEPTH(DEPTH), .RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
    .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_done_set(eng_done_set), .eng_arb_set(eng_arb_set),
    .eng_nak(eng_nak), .eng_need_data(eng_need_data), .eng_busy(eng_busy),
    .eng_scl(eng_scl), .eng_sda(eng_sda), .eng_reset(eng_reset),
    .eng_combined(eng_combined), .scl_lo_div(scl_lo_div), .scl_hi_div(scl_hi_div),
    .own_addr(own_addr), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_tx[$], m_rx[$];
  bit m_done, m_arb, m_irq;
  int m_ctrl, m_cnt, m_rxb, m_txb, m_lo, m_hi, m_own;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] s;
    case (a)
      8'h00: return (m_rx.size() > 0) ? 32'(m_rx[0]) : 0;
      8'h04: begin
        s = 0;
        s[0] = m_done; s[1] = m_arb; s[2] = eng_nak; s[3] = eng_need_data;
        s[5] = eng_busy; s[6] = eng_scl; s[7] = eng_sda;
        s[8] = (m_rx.size() == DEPTH); s[9] = (m_rx.size() == 0);
        s[10] = (m_tx.size() == DEPTH); s[11] = (m_tx.size() == 0);
        return s;
      end
      8'h08: return 32'(m_ctrl) | ((m_cnt != 0) ? 32'h100 : 0);
      8'h0C: return 32'(m_lo);
      8'h10: return 32'(m_hi);
      8'h14: return 32'(m_own);
      8'h18: return 32'(m_rx.size());
      8'h1C: return 32'(m_tx.size());
      8'h20: return 32'(m_rxb);
      8'h24: return 32'(m_txb);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit busy, txv;
    int txs, rxs;
    if (rst) begin
      m_tx.delete(); m_rx.delete();
      m_done = 0; m_arb = 0; m_irq = 0; m_ctrl = 0; m_cnt = 0;
      m_rxb = 0; m_txb = 0; m_lo = 'h3FF; m_hi = 'h3FF; m_own = 0; m_rdata = 0;
    end else begin
      busy = (m_cnt != 0);
      txs = m_tx.size(); rxs = m_rx.size();
      txv = (txs > 0) && !busy;
      m_irq = (m_done && m_ctrl[0]) || (m_arb && m_ctrl[1]) || (eng_nak && m_ctrl[2]) ||
              (eng_need_data && m_ctrl[3]) || (rxs == DEPTH && m_ctrl[5]) ||
              (rxs > 0 && m_ctrl[6]);
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (busy) begin
        m_tx.delete(); m_rx.delete(); m_rxb = 0; m_txb = 0; m_done = 0; m_arb = 0;
      end else begin
        if (eng_tx_pop && txs > 0) void'(m_tx.pop_front());
        if (bus_wr && bus_addr == 8'h00 && txs < DEPTH) m_tx.push_back(int'(bus_wdata[9:0]));
        if (bus_rd && bus_addr == 8'h00 && rxs > 0) void'(m_rx.pop_front());
        if (eng_rx_push && rxs < DEPTH) m_rx.push_back(int'(eng_rx_data));
        if (eng_rx_push) m_rxb = (m_rxb + 1) & 'hFFFF;
        if (eng_tx_pop && txv) m_txb = (m_txb + 1) & 'hFFFF;
        if (eng_done_set) m_done = 1;
        else if (bus_wr && bus_addr == 8'h04 && bus_wdata[0]) m_done = 0;
        if (eng_arb_set) m_arb = 1;
        else if (bus_wr && bus_addr == 8'h04 && bus_wdata[1]) m_arb = 0;
      end
      if (bus_wr && bus_addr == 8'h08 && bus_wdata[8]) m_cnt = RST_LEN;
      else if (m_cnt > 0) m_cnt--;
      if (bus_wr) begin
        case (bus_addr)
          8'h08: m_ctrl = int'(bus_wdata[10:0]) & 'h4FF;
          8'h0C: m_lo = int'(bus_wdata[9:0]);
          8'h10: m_hi = int'(bus_wdata[9:0]);
          8'h14: m_own = int'(bus_wdata[6:0]);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R13 rdata", bus_rdata, m_rdata);
      check("R8 irq", 32'(irq), 32'(m_irq));
      check("R9 eng_reset", 32'(eng_reset), 32'(m_cnt != 0));
      check("R2 tx_valid", 32'(eng_tx_valid), 32'(m_tx.size() > 0 && m_cnt == 0));
      if (eng_tx_valid && m_tx.size() > 0) check("R2 tx_data", 32'(eng_tx_data), 32'(m_tx[0]));
      check("R11 lo", 32'(scl_lo_div), 32'(m_lo));
      check("R11 hi", 32'(scl_hi_div), 32'(m_hi));
      check("R12 own", 32'(own_addr), 32'(m_own));
      check("R9 combined", 32'(eng_combined), 32'(m_ctrl[10]));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(req, bus_rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit timed_out = 0;
  initial begin
    #1600000;
    timed_out = 1;
  end

  initial begin
    fork
      begin
        tick(4);
        rst = 0;
        tick(1);
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 rdata", bus_rdata, 0);
        rd(8'h04, 32'h0000_0A00, "R1 status");
        rd(8'h08, 0, "R1 ctrl");
        rd(8'h0C, 32'h3FF, "R1 lo");
        rd(8'h10, 32'h3FF, "R1 hi");
        // R11 dividers
        wr(8'h0C, 32'hFFFF_F123);
        rd(8'h0C, 32'h123, "R11 lo");
        wr(8'h10, 32'h0000_02A5);
        rd(8'h10, 32'h2A5, "R11 hi");
        check("R11 port", 32'(scl_lo_div), 32'h123);
        // R12 own address and unmapped
        wr(8'h14, 32'hFF);
        rd(8'h14, 32'h7F, "R12 own");
        rd(8'h28, 0, "R12 slave fifo");
        rd(8'h2C, 0, "R12 slave level");
        rd(8'h30, 0, "R12 unmapped");
        // R2 / R3 TX queue
        wr(8'h00, 32'h1A5); wr(8'h00, 32'h2B6); wr(8'h00, 32'h0C7); wr(8'h00, 32'h3D8);
        wr(8'h00, 32'h155);
        rd(8'h1C, 4, "R3 tx level");
        rd(8'h04, 32'h0000_0600, "R3 tx full");
        check("R2 head", 32'(eng_tx_data), 32'h1A5);
        eng_tx_pop = 1; @(negedge clk);
        check("R2 fifo order", 32'(eng_tx_data), 32'h2B6);
        @(negedge clk);
        check("R2 fifo order", 32'(eng_tx_data), 32'h0C7);
        @(negedge clk);
        check("R2 fifo order", 32'(eng_tx_data), 32'h3D8);
        @(negedge clk);
        eng_tx_pop = 0;
        check("R3 dropped write absent", 32'(eng_tx_valid), 0);
        rd(8'h24, 4, "R10 tx count");
        // R4 / R5 RX queue
        for (int i = 1; i <= 5; i++) begin
          eng_rx_push = 1; eng_rx_data = 8'(i * 8'h11); @(negedge clk);
        end
        eng_rx_push = 0;
        rd(8'h18, 4, "R4 rx level");
        rd(8'h04, 32'h0000_0900, "R4 rx full");
        rd(8'h20, 5, "R10 rx count");
        rd(8'h00, 32'h11, "R4 rx data");
        rd(8'h00, 32'h22, "R4 rx data");
        rd(8'h00, 32'h33, "R4 rx data");
        rd(8'h00, 32'h44, "R5 last kept byte");
        rd(8'h00, 0, "R4 empty read");
        // R6 sticky flags
        eng_done_set = 1; eng_arb_set = 1; @(negedge clk);
        eng_done_set = 0; eng_arb_set = 0;
        rd(8'h04, 32'h0000_0A03, "R6 set");
        wr(8'h04, 0);
        rd(8'h04, 32'h0000_0A03, "R6 write zero");
        wr(8'h04, 1);
        rd(8'h04, 32'h0000_0A02, "R6 clear done");
        eng_done_set = 1; wr(8'h04, 3); eng_done_set = 0;
        rd(8'h04, 32'h0000_0A01, "R6 set wins");
        wr(8'h04, 1);
        rd(8'h04, 32'h0000_0A00, "R6 cleared");
        // R7 live levels
        eng_nak = 1; eng_need_data = 1; eng_busy = 1; eng_scl = 1; eng_sda = 1;
        rd(8'h04, 32'h0000_0AEC, "R7 levels");
        eng_need_data = 0; eng_busy = 0; eng_scl = 0; eng_sda = 0; eng_nak = 0;
        // R8 interrupt
        wr(8'h08, 32'h04);
        eng_nak = 1; @(negedge clk);
        check("R8 nak irq", 32'(irq), 1);
        eng_nak = 0; @(negedge clk);
        check("R8 nak irq gone", 32'(irq), 0);
        eng_done_set = 1; @(negedge clk); eng_done_set = 0;
        tick(1);
        check("R8 disabled done", 32'(irq), 0);
        wr(8'h08, 32'h41);
        tick(1);
        check("R8 done irq", 32'(irq), 1);
        wr(8'h04, 1);
        tick(1);
        check("R8 cleared", 32'(irq), 0);
        eng_rx_push = 1; eng_rx_data = 8'h5A; @(negedge clk); eng_rx_push = 0;
        tick(1);
        check("R8 rx avail", 32'(irq), 1);
        // R9 soft reset
        wr(8'h00, 32'h101); wr(8'h00, 32'h102);
        eng_done_set = 1; @(negedge clk); eng_done_set = 0;
        wr(8'h08, 32'h541);
        check("R9 eng_reset", 32'(eng_reset), 1);
        wr(8'h00, 32'h0AA);
        rd(8'h08, 32'h541, "R9 bit reads one");
        tick(RST_LEN);
        check("R9 eng_reset ended", 32'(eng_reset), 0);
        rd(8'h08, 32'h441, "R9 self clear");
        rd(8'h04, 32'h0000_0A00, "R9 flushed status");
        rd(8'h1C, 0, "R9 tx write dropped");
        rd(8'h20, 0, "R9 rx count");
        rd(8'h24, 0, "R9 tx count");
        check("R9 combined", 32'(eng_combined), 1);
        // randomised traffic
        for (int i = 0; i < 3000; i++) begin
          logic [7:0] a;
          a = 8'(($urandom % 11) * 4);
          bus_addr = a;
          bus_wr = ($urandom % 4) == 0;
          bus_rd = !bus_wr && (($urandom % 3) == 0);
          bus_wdata = $urandom;
          if (a == 8'h08 && ($urandom % 8) != 0) bus_wdata[8] = 0;
          eng_tx_pop = ($urandom % 3) == 0;
          eng_rx_push = ($urandom % 4) == 0;
          eng_rx_data = 8'($urandom);
          eng_done_set = ($urandom % 16) == 0;
          eng_arb_set = ($urandom % 16) == 0;
          eng_nak = ($urandom % 5) == 0;
          eng_need_data = ($urandom % 5) == 0;
          eng_busy = $urandom % 2;
          eng_scl = $urandom % 2;
          eng_sda = $urandom % 2;
          @(negedge clk);
        end
        bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
        eng_done_set = 0; eng_arb_set = 0;
        tick(2);
      end
      begin
        wait (timed_out);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule